// File: doc/BRIEF.md
# Two-Step Flash Converter Sequencer

This block is the digital controller of an 8-bit converter that resolves its result in two 4-bit flash passes. A host starts a conversion by pulling chip select and read low together. The block latches the channel address, holds the input in a track phase, and then turns the coarse comparator bank's 15-line thermometer code into the upper nibble. That nibble goes out to the residue DAC, and the fine bank's thermometer code then gives the lower nibble.

The upper nibble is visible in the output register as soon as the coarse pass ends. The active-low end-of-conversion flag only drops once the whole word is held. A host that can stall keeps read low for the whole conversion and picks up the word when the flag falls. A host that cannot stall releases read and comes back later with a read strobe. Each phase length is given in nanoseconds and converted to clock cycles from the clock frequency parameter.

Top module: `twostep_adc_seq`

## Requirements
- R1: A conversion starts on the clock edge that first sees chip select and read both low after a cycle in which they were not, while the block is idle. After that edge, `track` is high.
- R2: The address is captured at the start edge and driven on `chan_sel` as its low CH_W bits. With 8 channels, codes 0 to 7 select channels 0 to 7. With 4 channels, address bit 2 is ignored.
- R3: Each thermometer code is decoded by counting its asserted lines. A code with a single bubble decodes to the same value as the clean code with the same number of ones.
- R4: Track lasts TRACK_CYC = ceil(TRACK_NS*CLK_MHZ/1000) cycles. At its end, `track` falls, and the coarse nibble appears both on `dac_code` and on data bits 7:4, with bits 3:0 reading zero.
- R5: `eoc_n` falls exactly TRACK_CYC + FINE_CYC cycles after the start edge, with FINE_CYC = ceil(FINE_NS*CLK_MHZ/1000). At that point the data holds {coarse nibble, fine nibble}.
- R6: `data_en` is high only while chip select and read are both low.
- R7: Once the conversion is done, `eoc_n` returns high on the clock edge that sees the select condition end, and the block goes idle.
- R8: A new select edge while a conversion is in progress, or while its result is waiting to be read, starts nothing. The channel and the completion time stay unchanged.
- R9: After reset, `eoc_n` is high, `track` is low, and `dac_code`, `chan_sel` and `data_en` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| addr | input | 3 | Channel address |
| eoc_n | output | 1 | End of conversion, active low |
| data_o | output | 8 | Result word for the bus pad |
| data_en | output | 1 | Bus drive enable for the three-state pad |
| coarse_therm | input | 15 | Coarse comparator bank outputs |
| fine_therm | input | 15 | Fine comparator bank outputs |
| chan_sel | output | CH_W | Analog mux select |
| track | output | 1 | High while the input is tracked |
| dac_code | output | 4 | Code for the residue DAC |

## Verification
The bench drives the extreme words 0x00 and 0xFF. Here a decoder that drops the top comparator line would return 0xEF, and a residue computed from the wrong DAC code would corrupt the low nibble. It injects a bubble into the coarse code, which a priority-style decoder would misread as a much smaller value. It re-strobes select in the middle of a conversion with a different address; a design that restarted would move `chan_sel` and finish late. It also checks the early-release host pattern, where a design that keyed the flag's return to the wrong edge would leave `eoc_n` stuck low. The phase boundaries are checked on the exact cycle, so a counter that is off by one shows up at once.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int NIB_W   = 4;
  localparam int THERM_W = (1 << NIB_W) - 1;
  localparam int WORD_W  = 2 * NIB_W;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_TRACK,
    ST_FINE,
    ST_DONE
  } seq_state_t;
endpackage

// File: rtl/therm_count.sv
// Counts asserted comparator lines; tolerant of isolated bubbles.
module therm_count #(
  parameter int W  = 15,
  parameter int OW = $clog2(W + 1)
) (
  input  logic [W-1:0]  therm,
  output logic [OW-1:0] code
);
  always_comb begin
    code = '0;
    for (int i = 0; i < W; i++) begin
      code = code + OW'(therm[i]);
    end
  end
endmodule

// File: rtl/phase_timer.sv
// Down-counter for phase lengths; expired while the count sits at zero.
module phase_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/twostep_adc_seq.sv
module twostep_adc_seq
  import adc_seq_pkg::*;
#(
  parameter int CLK_MHZ  = 50,
  parameter int TRACK_NS = 1000,
  parameter int FINE_NS  = 600,
  parameter int NUM_CH   = 8,
  parameter int CH_W     = $clog2(NUM_CH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cs_n,
  input  logic                rd_n,
  input  logic [2:0]          addr,
  output logic                eoc_n,
  output logic [WORD_W-1:0]   data_o,
  output logic                data_en,
  input  logic [THERM_W-1:0]  coarse_therm,
  input  logic [THERM_W-1:0]  fine_therm,
  output logic [CH_W-1:0]     chan_sel,
  output logic                track,
  output logic [NIB_W-1:0]    dac_code
);
  localparam int TRACK_CYC = (TRACK_NS * CLK_MHZ + 999) / 1000;
  localparam int FINE_CYC  = (FINE_NS * CLK_MHZ + 999) / 1000;
  localparam int MAX_CYC   = (TRACK_CYC > FINE_CYC) ? TRACK_CYC : FINE_CYC;
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  seq_state_t        state;
  logic              sel, sel_q, start;
  logic              tmr_load, tmr_done;
  logic [CNT_W-1:0]  tmr_val;
  logic [NIB_W-1:0]  coarse_code, fine_code;
  logic [CH_W-1:0]   addr_sel;

  assign sel   = !cs_n && !rd_n;
  assign start = sel && !sel_q;

  // Channel field: low CH_W address bits; upper bits ignored for narrow muxes.
  generate
    if (CH_W >= 3) begin : g_full_addr
      assign addr_sel = CH_W'(addr);
    end else begin : g_narrow_addr
      assign addr_sel = addr[CH_W-1:0];
    end
  endgenerate

  therm_count #(.W(THERM_W), .OW(NIB_W)) u_coarse_dec (
    .therm (coarse_therm),
    .code  (coarse_code)
  );

  therm_count #(.W(THERM_W), .OW(NIB_W)) u_fine_dec (
    .therm (fine_therm),
    .code  (fine_code)
  );

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = CNT_W'(TRACK_CYC - 1);
    if (state == ST_IDLE && start) begin
      tmr_load = 1'b1;
    end else if (state == ST_TRACK && tmr_done) begin
      tmr_load = 1'b1;
      tmr_val  = CNT_W'(FINE_CYC - 1);
    end
  end

  phase_timer #(.CW(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      sel_q    <= 1'b0;
      chan_sel <= '0;
      track    <= 1'b0;
      dac_code <= '0;
      data_o   <= '0;
      eoc_n    <= 1'b1;
    end else begin
      sel_q <= sel;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            chan_sel <= addr_sel;
            data_o   <= '0;
            dac_code <= '0;
            track    <= 1'b1;
            state    <= ST_TRACK;
          end
        end
        ST_TRACK: begin
          if (tmr_done) begin
            data_o[WORD_W-1:NIB_W] <= coarse_code;
            dac_code               <= coarse_code;
            track                  <= 1'b0;
            state                  <= ST_FINE;
          end
        end
        ST_FINE: begin
          if (tmr_done) begin
            data_o[NIB_W-1:0] <= fine_code;
            eoc_n             <= 1'b0;
            state             <= ST_DONE;
          end
        end
        ST_DONE: begin
          if (sel_q && !sel) begin
            eoc_n <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign data_en = sel;
endmodule

// File: rtl/twostep_adc_seq_chk.sv
module twostep_adc_seq_chk
  import adc_seq_pkg::*;
#(
  parameter int CH_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             cs_n,
  input logic             rd_n,
  input logic             eoc_n,
  input logic             track,
  input logic [NIB_W-1:0] dac_code,
  input logic [CH_W-1:0]  chan_sel,
  input seq_state_t       state
);
  // R1
  track_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(track) |-> ($past(state) == ST_IDLE && $past(!cs_n && !rd_n)));

  // R8
  chan_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(chan_sel));

  // R4
  dac_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FINE && $past(state) == ST_FINE) |-> $stable(dac_code));

  // R5
  eoc_after_fine_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(eoc_n) |-> ($past(state) == ST_FINE));

  // R7
  eoc_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(eoc_n) |-> ($past(!cs_n && !rd_n, 2) && !$past(!cs_n && !rd_n)));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> (eoc_n && !track));
endmodule

bind twostep_adc_seq twostep_adc_seq_chk #(.CH_W(CH_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cs_n     (cs_n),
  .rd_n     (rd_n),
  .eoc_n    (eoc_n),
  .track    (track),
  .dac_code (dac_code),
  .chan_sel (chan_sel),
  .state    (state)
);

// File: tb/twostep_adc_seq_bench.sv
`timescale 1ns/1ps
module twostep_adc_seq_bench;
  localparam int CLK_MHZ   = 125;
  localparam int TRACK_NS  = 1000;
  localparam int FINE_NS   = 600;
  localparam int TRACK_CYC = (TRACK_NS * CLK_MHZ + 999) / 1000;
  localparam int FINE_CYC  = (FINE_NS * CLK_MHZ + 999) / 1000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1, rd_n = 1'b1;
  logic [2:0]  addr = '0;
  logic        eoc_n, data_en, track;
  logic [7:0]  data_o;
  logic [14:0] coarse_therm, fine_therm;
  logic [2:0]  chan_sel;
  logic [3:0]  dac_code;

  logic        eoc4_n, data_en4, track4;
  logic [7:0]  data4;
  logic [1:0]  chan4;
  logic [3:0]  dac4;

  logic [7:0]  ain [8];
  logic        bubble = 1'b0;
  logic [7:0]  exp_q [$];
  int          cyc = 0, start_cyc = 0;
  int          n_tests = 0, n_fail = 0;
  logic        prev_eoc = 1'b1;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  twostep_adc_seq #(.CLK_MHZ(CLK_MHZ), .TRACK_NS(TRACK_NS), .FINE_NS(FINE_NS), .NUM_CH(8))
  u_twostep_adc_seq (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .addr(addr), .eoc_n(eoc_n),
    .data_o(data_o), .data_en(data_en), .coarse_therm(coarse_therm),
    .fine_therm(fine_therm), .chan_sel(chan_sel), .track(track), .dac_code(dac_code)
  );

  twostep_adc_seq #(.CLK_MHZ(CLK_MHZ), .TRACK_NS(TRACK_NS), .FINE_NS(FINE_NS), .NUM_CH(4))
  u_twostep_adc_seq_4ch (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .addr(addr), .eoc_n(eoc4_n),
    .data_o(data4), .data_en(data_en4), .coarse_therm(coarse_therm),
    .fine_therm(fine_therm), .chan_sel(chan4), .track(track4), .dac_code(dac4)
  );

  function automatic logic [14:0] therm(input int n);
    logic [14:0] t;
    for (int i = 0; i < 15; i++) t[i] = (i < n);
    return t;
  endfunction

  // Comparator bank model: coarse from the input, fine from the residue.
  always_comb begin
    int v, n, r;
    v = int'(ain[chan_sel]);
    n = v / 16;
    coarse_therm = therm(n);
    if (bubble && n >= 2 && n <= 14) begin
      coarse_therm[n-2] = 1'b0;
      coarse_therm[n]   = 1'b1;
    end
    r = v - 16 * int'(dac_code);
    if (r < 0) r = 0;
    if (r > 15) r = 15;
    fine_therm = therm(r);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Monitor: completion timing and word from the scoreboard queue.
  always @(negedge clk) begin
    if (!rst && prev_eoc && !eoc_n) begin
      chk(cyc - start_cyc == TRACK_CYC + FINE_CYC, "R5 eoc timing",
          cyc - start_cyc, TRACK_CYC + FINE_CYC);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected completion", data_o, 0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(data_o == e, "R5 R3 result word", data_o, e);
      end
    end
    prev_eoc <= eoc_n;
  end

  task automatic convert(input int ch, input bit early, input bit poke, input bit bub);
    logic [7:0] v;
    v = ain[ch];
    @(negedge clk);
    addr = 3'(ch); cs_n = 1'b0; rd_n = 1'b0; bubble = bub;
    exp_q.push_back(v);
    @(posedge clk); #1 start_cyc = cyc;
    @(negedge clk);
    chk(track == 1'b1, "R1 track after start", track, 1);
    chk(chan_sel == 3'(ch), "R2 channel", chan_sel, ch);
    chk(chan4 == 2'(ch), "R2 four-channel select", chan4, ch & 3);
    if (early) begin
      rd_n = 1'b1; #1;
      chk(data_en == 1'b0, "R6 bus released", data_en, 0);
    end
    if (poke) begin
      repeat (10) @(negedge clk);
      cs_n = 1'b1; rd_n = 1'b1;
      @(negedge clk);
      addr = 3'(ch ^ 3); cs_n = 1'b0; rd_n = 1'b0;
      @(negedge clk);
      chk(chan_sel == 3'(ch), "R8 busy restart ignored", chan_sel, ch);
    end
    while (cyc != start_cyc + TRACK_CYC) @(negedge clk);
    chk(track == 1'b0, "R4 track end", track, 0);
    chk(dac_code == v[7:4], "R4 dac code", dac_code, v[7:4]);
    chk(data_o == {v[7:4], 4'h0}, "R4 early upper nibble", data_o, {v[7:4], 4'h0});
    chk(eoc_n == 1'b1, "R5 no early eoc", eoc_n, 1);
    while (eoc_n) @(negedge clk);
    if (early) begin
      @(negedge clk);
      chk(eoc_n == 1'b0, "R8 flag held until read", eoc_n, 0);
      cs_n = 1'b0; rd_n = 1'b0; #1;
      chk(data_en == 1'b1, "R6 bus driven on read", data_en, 1);
      chk(data_o == v, "R5 word on read", data_o, v);
    end
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
    chk(eoc_n == 1'b1, "R7 eoc returns", eoc_n, 1);
    chk(data_en == 1'b0, "R6 bus off", data_en, 0);
    bubble = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    wait (cyc > 150000);
    chk(1'b0, "watchdog", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    ain[0] = 8'h00; ain[1] = 8'h11; ain[2] = 8'h93; ain[3] = 8'h5A;
    ain[4] = 8'hC4; ain[5] = 8'h31; ain[6] = 8'h7C; ain[7] = 8'hFF;
    repeat (4) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(eoc_n == 1'b1, "R9 eoc reset", eoc_n, 1);
    chk(track == 1'b0, "R9 track reset", track, 0);
    chk(dac_code == 4'h0, "R9 dac reset", dac_code, 0);
    chk(chan_sel == 3'h0, "R9 chan reset", chan_sel, 0);
    chk(data_en == 1'b0, "R9 bus reset", data_en, 0);

    convert(3, 1'b0, 1'b0, 1'b0);
    convert(7, 1'b0, 1'b0, 1'b0);
    convert(0, 1'b0, 1'b0, 1'b0);
    convert(6, 1'b0, 1'b0, 1'b1);  // R3 bubble in coarse code
    convert(2, 1'b1, 1'b0, 1'b0);
    convert(5, 1'b0, 1'b1, 1'b0);
    convert(4, 1'b0, 1'b0, 1'b0);

    chk(exp_q.size() == 0, "R5 all results seen", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule